// File: doc/BRIEF.md
# Two-Wire Bus Link Controller

This block sits between two independent two-wire serial buses, called side A (input) and side B (output). Each side has a data line and a clock line. The block decides when the two sides may be joined. Once they are joined, it copies each low level across to the other side. It does this through four open-drain pull-down requests. The raw line levels arrive as inputs and pass through synchronisers. The pull-down requests leave as registered outputs, which drive external open-drain pads.

The block stays dark while the supply is not yet good, and whenever the enable input is low. When it is released, it watches both buses and joins them only at a safe point. A safe point is one of two cases: both buses have been quiet for a full idle window, or one bus has just finished a transaction with a stop while the other bus is quiet. A ready flag reports the joined state, so it can gate a downstream hot-plug or presence signal.

While joined, the block remembers which side started each low. It only mirrors a low from the side that an outside device holds low. For a short window after it releases its own pull-down on a side, it ignores lows sensed on that side, so the low it drove itself is not taken for a device. This keeps the digital wired-AND from locking itself low.

Top module: `twb_link_ctrl`

## Requirements
- R1: During reset, and on the clock edge after `pwr_good` is seen low, `link_on`, `ready` and all four pull-down requests are 0.
- R2: While `pwr_good` is low, line activity has no effect, and the idle counters are held at zero. After `pwr_good` returns (with `enable` high and all lines high), the link is not made before IDLE_CYCLES-1 cycles have passed.
- R3: A side counts as idle once its data and clock lines have both been sampled high for IDLE_CYCLES consecutive cycles. IDLE_CYCLES = IDLE_US*CLK_KHZ/1000, and IDLE_US must lie in 55..175. The default is 95 µs at 1000 kHz, which gives 95 cycles. With both sides idle, the link is made within IDLE_CYCLES+3 cycles of the last release.
- R4: A stop (data rising while clock is high) on one side, while the other side is idle, makes the link within 6 cycles of the stop.
- R5: A stop on one side while the other side is not idle does not make the link.
- R6: On the edge after `enable` is seen low, `link_on`, `ready` and all pull-down requests go to 0, and they stay at 0 while `enable` is low.
- R7: A rising `enable` does not join the buses at once (there is at least one cycle of qualification). With both sides already idle, the link follows within 3 cycles.
- R8: `ready` is 1 exactly when `link_on` is 1, so it is high only with `enable` high and the buses joined.
- R9: While linked, an outside low on one side's data or clock line raises the pull-down request for the same line on the other side within 5 cycles. The request on the side that is driven low stays 0.
- R10: When every device on both sides has released a line, both pull-down requests for that line fall within 8 cycles and stay low (no self-holding).
- R11: If both sides hold a line low and the side that started the low releases first, then after settling the block pulls that released side low and no longer pulls the other side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_good | input | 1 | Supply good; low means lockout |
| enable | input | 1 | Allow the link; low isolates the buses at once |
| in_sda_i | input | 1 | Sensed data line level, side A |
| in_scl_i | input | 1 | Sensed clock line level, side A |
| out_sda_i | input | 1 | Sensed data line level, side B |
| out_scl_i | input | 1 | Sensed clock line level, side B |
| in_sda_pd | output | 1 | Pull-down request, side A data |
| in_scl_pd | output | 1 | Pull-down request, side A clock |
| out_sda_pd | output | 1 | Pull-down request, side B data |
| out_scl_pd | output | 1 | Pull-down request, side B clock |
| link_on | output | 1 | Buses joined |
| ready | output | 1 | Link ready flag |

## Verification
A wrong link state machine shows up at `link_on` and `ready`. Such a fault makes the link appear too early after the enable or supply returns, or fail to appear within a few cycles of a qualifying stop or idle. It is visible one idle window after release at most.

A wrong ownership or blanking state shows up on the pull-down requests. Either a request stays high after every device has released the line, which is a latch-up visible within about ten cycles, or a low is not mirrored within five cycles. A wrong idle counter moves the link time away from the IDLE_CYCLES window by a measurable number of cycles.

// File: rtl/twb_pkg.sv
package twb_pkg;
  typedef enum logic [1:0] {
    LK_LOCK = 2'd0,
    LK_OFF  = 2'd1,
    LK_QUAL = 2'd2,
    LK_LINK = 2'd3
  } link_st_e;

  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_A    = 2'd1,
    OWN_B    = 2'd2
  } own_e;
endpackage

// File: rtl/twb_sync.sv
module twb_sync #(
  parameter int STAGES = 2,
  parameter int W      = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  // Lines idle high, so the chain resets to ones.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '1;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/twb_bus_watch.sv
module twb_bus_watch #(
  parameter int IDLE_CYCLES = 95
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic sda,
  input  logic scl,
  output logic idle,
  output logic stop
);
  localparam int CW = $clog2(IDLE_CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic          sda_p, scl_p;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q <= '0;
      sda_p <= 1'b1;
      scl_p <= 1'b1;
    end else begin
      sda_p <= sda;
      scl_p <= scl;
      if (sda && scl) begin
        if (cnt_q != CW'(IDLE_CYCLES)) cnt_q <= cnt_q + 1'b1;
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign idle = (cnt_q == CW'(IDLE_CYCLES));
  assign stop = sda && !sda_p && scl && scl_p;

  // Idle flag must be backed by both lines high on the previous sample.
  assert_idle_needs_high_R3: assert property (@(posedge clk) disable iff (rst)
    idle |-> $past(sda && scl));

  // Lockout clears the window.
  assert_idle_cleared_R2: assert property (@(posedge clk) disable iff (rst)
    $past(clr) |-> !idle);
endmodule

// File: rtl/twb_wand.sv
module twb_wand
  import twb_pkg::*;
#(
  parameter int BLANK = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic link,   // next-cycle link state
  input  logic a_lvl,  // synchronised level, side A
  input  logic b_lvl,  // synchronised level, side B
  output logic pd_a,
  output logic pd_b
);
  localparam int BW = $clog2(BLANK + 1);

  own_e          own_q, own_n;
  logic [BW-1:0] blk_a_q, blk_b_q;
  logic          a_low, b_low;

  // A low counts only once the echo of our own pull-down has drained.
  assign a_low = !a_lvl && (blk_a_q == '0);
  assign b_low = !b_lvl && (blk_b_q == '0);

  always_comb begin
    own_n = own_q;
    if (!link) begin
      own_n = OWN_NONE;
    end else begin
      case (own_q)
        OWN_NONE: begin
          if (a_low)      own_n = OWN_A;
          else if (b_low) own_n = OWN_B;
        end
        OWN_A:   if (a_lvl) own_n = OWN_NONE;
        OWN_B:   if (b_lvl) own_n = OWN_NONE;
        default: own_n = OWN_NONE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      own_q   <= OWN_NONE;
      blk_a_q <= '0;
      blk_b_q <= '0;
      pd_a    <= 1'b0;
      pd_b    <= 1'b0;
    end else begin
      own_q <= own_n;
      pd_a  <= (own_n == OWN_B);
      pd_b  <= (own_n == OWN_A);

      if (!link)                                 blk_a_q <= '0;
      else if (own_q == OWN_B && own_n != OWN_B) blk_a_q <= BW'(BLANK);
      else if (blk_a_q != '0)                    blk_a_q <= blk_a_q - 1'b1;

      if (!link)                                 blk_b_q <= '0;
      else if (own_q == OWN_A && own_n != OWN_A) blk_b_q <= BW'(BLANK);
      else if (blk_b_q != '0)                    blk_b_q <= blk_b_q - 1'b1;
    end
  end

  // A mirrored low always has a sensed low on the originating side behind it.
  assert_mirror_from_a_R9: assert property (@(posedge clk) disable iff (rst)
    pd_b |-> !$past(a_lvl));
  assert_mirror_from_b_R9: assert property (@(posedge clk) disable iff (rst)
    pd_a |-> !$past(b_lvl));
  // Nothing is pulled while the link is being torn down.
  assert_unlinked_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(link) |-> !pd_a && !pd_b);
endmodule

// File: rtl/twb_link_ctrl.sv
module twb_link_ctrl
  import twb_pkg::*;
#(
  parameter int CLK_KHZ     = 1000,
  parameter int IDLE_US     = 95,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_good,
  input  logic enable,
  input  logic in_sda_i,
  input  logic in_scl_i,
  input  logic out_sda_i,
  input  logic out_scl_i,
  output logic in_sda_pd,
  output logic in_scl_pd,
  output logic out_sda_pd,
  output logic out_scl_pd,
  output logic link_on,
  output logic ready
);
  localparam int IDLE_CYCLES = IDLE_US * CLK_KHZ / 1000;
  localparam int BLANK       = SYNC_STAGES + 1;
  localparam int NSIDE       = 2;
  localparam int NLINE       = 2;  // 0: data, 1: clock

  initial begin
    assert_idle_window_R3: assert (IDLE_US >= 55 && IDLE_US <= 175 && IDLE_CYCLES > 0);
  end

  // Synchronised levels: [side*2 + line]
  logic [2*NSIDE-1:0] lv;
  twb_sync #(.STAGES(SYNC_STAGES), .W(2*NSIDE)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({out_scl_i, out_sda_i, in_scl_i, in_sda_i}),
    .q   (lv)
  );

  logic [NSIDE-1:0] side_idle, side_stop;

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    twb_bus_watch #(.IDLE_CYCLES(IDLE_CYCLES)) u_watch (
      .clk  (clk),
      .rst  (rst),
      .clr  (!pwr_good),
      .sda  (lv[2*s]),
      .scl  (lv[2*s+1]),
      .idle (side_idle[s]),
      .stop (side_stop[s])
    );
  end

  link_st_e st_q, st_n;
  logic     qual_ok, link_nxt;

  assign qual_ok = (side_idle[0] && side_idle[1]) ||
                   (side_stop[0] && side_idle[1]) ||
                   (side_stop[1] && side_idle[0]);

  always_comb begin
    st_n = st_q;
    if (!pwr_good) begin
      st_n = LK_LOCK;
    end else if (!enable) begin
      st_n = LK_OFF;
    end else begin
      case (st_q)
        LK_LOCK, LK_OFF: st_n = LK_QUAL;
        LK_QUAL:         st_n = qual_ok ? LK_LINK : LK_QUAL;
        LK_LINK:         st_n = LK_LINK;
        default:         st_n = LK_LOCK;
      endcase
    end
  end

  assign link_nxt = (st_n == LK_LINK);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= LK_LOCK;
      link_on <= 1'b0;
      ready   <= 1'b0;
    end else begin
      st_q    <= st_n;
      link_on <= link_nxt;
      ready   <= link_nxt && enable;
    end
  end

  logic [NLINE-1:0] pd_in, pd_out;

  for (genvar l = 0; l < NLINE; l++) begin : g_line
    twb_wand #(.BLANK(BLANK)) u_wand (
      .clk   (clk),
      .rst   (rst),
      .link  (link_nxt),
      .a_lvl (lv[l]),
      .b_lvl (lv[2+l]),
      .pd_a  (pd_in[l]),
      .pd_b  (pd_out[l])
    );
  end

  assign in_sda_pd  = pd_in[0];
  assign in_scl_pd  = pd_in[1];
  assign out_sda_pd = pd_out[0];
  assign out_scl_pd = pd_out[1];

  assert_dark_in_lockout_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(pwr_good) |-> !link_on && !ready);
  assert_enable_low_isolates_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(enable) |-> !link_on && !ready &&
                       !in_sda_pd && !in_scl_pd && !out_sda_pd && !out_scl_pd);
  assert_link_needs_qual_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(link_on) |-> $past(qual_ok));
  assert_ready_means_link_R8: assert property (@(posedge clk) disable iff (rst)
    ready |-> link_on && $past(enable));
endmodule

// File: tb/twb_link_ctrl_bench.sv
module twb_link_ctrl_bench;
  localparam int CLK_NS = 10;
  localparam int IDLE   = 95;

  logic clk = 1'b0;
  logic rst, pwr_good, enable;
  logic ext_a_sda, ext_a_scl, ext_b_sda, ext_b_scl;  // 1 = outside device pulls low
  logic in_sda, in_scl, out_sda, out_scl;
  logic in_sda_pd, in_scl_pd, out_sda_pd, out_scl_pd, link_on, ready;
  int   n_chk = 0, n_err = 0;
  bit   done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  assign in_sda  = ~(ext_a_sda | in_sda_pd);
  assign in_scl  = ~(ext_a_scl | in_scl_pd);
  assign out_sda = ~(ext_b_sda | out_sda_pd);
  assign out_scl = ~(ext_b_scl | out_scl_pd);

  twb_link_ctrl u_twb_link_ctrl (
    .clk(clk), .rst(rst), .pwr_good(pwr_good), .enable(enable),
    .in_sda_i(in_sda), .in_scl_i(in_scl), .out_sda_i(out_sda), .out_scl_i(out_scl),
    .in_sda_pd(in_sda_pd), .in_scl_pd(in_scl_pd),
    .out_sda_pd(out_sda_pd), .out_scl_pd(out_scl_pd),
    .link_on(link_on), .ready(ready)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [3:0] pds();
    return {in_sda_pd, in_scl_pd, out_sda_pd, out_scl_pd};
  endfunction

  task automatic t_reset();
    rst = 1; pwr_good = 0; enable = 0;
    ext_a_sda = 0; ext_a_scl = 0; ext_b_sda = 0; ext_b_scl = 0;
    cyc(5);
    chk("R1 link in reset", link_on, 0);
    chk("R1 ready in reset", ready, 0);
    chk("R1 pulls in reset", pds(), 0);
    rst = 0;
  endtask

  task automatic t_lockout();
    enable = 1;
    cyc(150);
    ext_a_sda = 1; cyc(4); ext_a_scl = 1; cyc(4); ext_a_scl = 0; cyc(4); ext_a_sda = 0;
    cyc(10);
    chk("R2 no link in lockout", link_on, 0);
    chk("R1 no ready in lockout", ready, 0);
  endtask

  task automatic t_idle_connect();
    pwr_good = 1;
    cyc(IDLE - 1);
    chk("R2 no early link after lockout", link_on, 0);
    cyc(4);
    chk("R3 link after idle window", link_on, 1);
    chk("R8 ready with link", ready, 1);
  endtask

  task automatic t_wand();
    ext_a_sda = 1; cyc(5);
    chk("R9 A data low mirrored to B", out_sda_pd, 1);
    chk("R9 A data not self-pulled", in_sda_pd, 0);
    ext_a_sda = 0; cyc(8);
    chk("R10 data released", pds(), 0);
    cyc(10);
    chk("R10 data stays released", pds(), 0);
    chk("R10 lines high", {in_sda, out_sda}, 2'b11);
    ext_b_scl = 1; cyc(5);
    chk("R9 B clock low mirrored to A", in_scl_pd, 1);
    chk("R9 B clock not self-pulled", out_scl_pd, 0);
    ext_a_scl = 1; cyc(3);
    ext_b_scl = 0; cyc(10);
    chk("R11 handover pulls B", out_scl_pd, 1);
    chk("R11 handover drops A pull", in_scl_pd, 0);
    ext_a_scl = 0; cyc(10);
    chk("R10 clock released", pds(), 0);
  endtask

  task automatic t_enable_drop();
    ext_a_sda = 1; cyc(5);
    chk("R9 pull active before drop", out_sda_pd, 1);
    enable = 0; cyc(1);
    chk("R6 link off next edge", link_on, 0);
    chk("R6 ready off next edge", ready, 0);
    chk("R6 pulls off next edge", pds(), 0);
    ext_a_sda = 0;
    cyc(IDLE + 20);
    chk("R6 stays isolated", link_on, 0);
  endtask

  task automatic t_enable_rise();
    enable = 1; cyc(1);
    chk("R7 no immediate link", link_on, 0);
    cyc(2);
    chk("R7 link after qualification", link_on, 1);
    chk("R8 ready follows link", ready, 1);
  endtask

  task automatic t_stop_connect();
    enable = 0; cyc(2);
    ext_a_sda = 1; cyc(5); ext_a_scl = 1; cyc(5); ext_a_scl = 0; cyc(5);
    enable = 1; cyc(5);
    chk("R3 no link with A busy", link_on, 0);
    ext_a_sda = 0; cyc(6);
    chk("R4 link after stop on A", link_on, 1);
    chk("R8 ready after stop link", ready, 1);
  endtask

  task automatic t_stop_blocked();
    enable = 0; cyc(2);
    ext_a_sda = 1; ext_b_sda = 1; cyc(5);
    enable = 1;
    ext_b_sda = 0; cyc(10);
    ext_a_sda = 0; cyc(8);
    chk("R5 stop with other side busy", link_on, 0);
    cyc(IDLE - 2);
    chk("R3 link once both idle", link_on, 1);
  endtask

  task automatic t_pg_drop();
    pwr_good = 0; cyc(1);
    chk("R1 link off on power loss", link_on, 0);
    chk("R1 ready off on power loss", ready, 0);
    ext_b_sda = 1; cyc(3); ext_b_sda = 0; cyc(10);
    pwr_good = 1;
    cyc(IDLE - 1);
    chk("R2 idle count restarted", link_on, 0);
    cyc(5);
    chk("R3 relink after power return", link_on, 1);
  endtask

  initial begin
    t_reset();
    t_lockout();
    t_idle_connect();
    t_wand();
    t_enable_drop();
    t_enable_rise();
    t_stop_connect();
    t_stop_blocked();
    t_pg_drop();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule